// File: doc/BRIEF.md
# Value Reuse Validation Scoreboard

This block sits on the trailing core of a two-core look-ahead pair. It chooses which instructions get result values forwarded from the leading core, and which value-predicted instructions may skip re-execution. Two structures do this work. The first is a slow-instruction filter, a counting membership filter keyed by instruction word address. During a training window that opens at each new loop, it learns which PCs waited a long time between dispatch and execute. The leading core queries it to decide whether to forward a value. A value misprediction takes that PC back out.

The second is a decode-stage scoreboard with one mark per architectural register. A value-predicted ALU result marks its destination as validated. Any other writer clears the mark. An instruction that carries a predicted value and whose valid source operands are all marked is flagged to skip validation, so chains of forwarded ALU results need no execution.

Top module: `vr_reuse_sb`

## Requirements
- R1: After reset the filter is empty (no lookup hits), every register mark is clear and training is off.
- R2: A `loop_start_i` pulse empties the filter from the next cycle and opens a training window. Latency reports, removals and iteration pulses in that same cycle are ignored.
- R3: A training window closes after 8 `iter_end_i` pulses. A report in the cycle of the 8th pulse is still recorded, and reports outside any window are dropped.
- R4: A report is recorded only if its dispatch-to-execute latency is 20 cycles or more.
- R5: Each of 64 entries is a 4-bit counter that saturates at 15. For a word address split into 6-bit slices s0, s1, ... (s0 lowest), h1 is the XOR of all slices and h2 is the XOR of slice k rotated left by k mod 6. Recording increments the counters at h1 and h2 (only once if h1 equals h2). A lookup hits in the same cycle when both counters are nonzero.
- R6: A misprediction for a PC that is currently a member decrements each of its counters that is below 15 (only once if h1 equals h2). A non-member is ignored. When recording and removal fall in the same cycle, both take effect on the counters.
- R7: A decoded, value-predicted ALU instruction that writes a register marks it validated from the next cycle.
- R8: A decoded write without a prediction, or by a non-ALU instruction such as a load, clears the mark. An instruction that does not write leaves every mark unchanged.
- R9: `dec_skip_o` is high in the same cycle exactly when a valid decoded instruction has a prediction and every source flagged valid is marked.
- R10: When an instruction reads the register it writes, the skip decision uses the mark held before that instruction's own update.
- R11: `flush_i` clears every mark for the next cycle and overrides that cycle's decode update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| loop_start_i | input | 1 | New loop entered |
| iter_end_i | input | 1 | One loop iteration completed |
| lat_vld_i | input | 1 | Latency report valid |
| lat_pc_i | input | 30 | Word address of the reported instruction |
| lat_cycles_i | input | 8 | Dispatch-to-execute latency in cycles |
| lkp_pc_i | input | 30 | Word address queried by the look-ahead side |
| lkp_hit_o | output | 1 | Queried PC is in the filter |
| mispred_vld_i | input | 1 | Value misprediction reported |
| mispred_pc_i | input | 30 | Word address of the mispredicted instruction |
| flush_i | input | 1 | Pipeline flush |
| dec_vld_i | input | 1 | Decode slot holds an instruction |
| dec_pred_i | input | 1 | Instruction carries a forwarded value |
| dec_alu_i | input | 1 | Instruction is a plain ALU operation |
| dec_wr_i | input | 1 | Instruction writes a destination register |
| dec_rd_i | input | 5 | Destination register |
| dec_rs1_vld_i | input | 1 | First source is used |
| dec_rs1_i | input | 5 | First source register |
| dec_rs2_vld_i | input | 1 | Second source is used |
| dec_rs2_i | input | 5 | Second source register |
| dec_skip_o | output | 1 | Instruction may skip validation |

## Verification
Recording a slow PC and removing a mispredicted PC can fall in the same cycle, and they can hit the same counter. The bench drives a directed cycle where one PC is both reported slow and mispredicted. Random traffic over a small PC pool then produces many shared-hash overlaps. The reference model judges each cycle by applying both updates to its own counter array, and checks the next lookup. The second collision is a read and a write of the same register in one decode slot. Here the skip must reflect the mark held before the update, and a same-cycle flush must win over the update.

// File: rtl/vr_pkg.sv
package vr_pkg;
  typedef enum logic {
    TRN_IDLE   = 1'b0,
    TRN_ACTIVE = 1'b1
  } trn_state_e;
endpackage

// File: rtl/vr_train_ctrl.sv
module vr_train_ctrl
  import vr_pkg::*;
#(
  parameter int unsigned TRAIN_ITERS = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic loop_start_i,
  input  logic iter_end_i,
  output logic training_o
);
  localparam int unsigned ITW = $clog2(TRAIN_ITERS + 1);

  trn_state_e     state_q;
  logic [ITW-1:0] iter_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= TRN_IDLE;
      iter_q  <= '0;
    end else if (loop_start_i) begin
      state_q <= TRN_ACTIVE;
      iter_q  <= '0;
    end else if (state_q == TRN_ACTIVE && iter_end_i) begin
      if (iter_q == ITW'(TRAIN_ITERS - 1)) begin
        state_q <= TRN_IDLE;
        iter_q  <= '0;
      end else begin
        iter_q <= iter_q + 1'b1;
      end
    end
  end

  assign training_o = (state_q == TRN_ACTIVE);
endmodule

// File: rtl/vr_slow_filter.sv
module vr_slow_filter #(
  parameter int unsigned PC_W  = 30,
  parameter int unsigned IDX_W = 6,
  parameter int unsigned CNT_W = 4
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            clr_i,
  input  logic            ins_i,
  input  logic [PC_W-1:0] ins_pc_i,
  input  logic            rem_i,
  input  logic [PC_W-1:0] rem_pc_i,
  input  logic [PC_W-1:0] lkp_pc_i,
  output logic            lkp_hit_o
);
  localparam int unsigned N     = 1 << IDX_W;
  localparam int unsigned NCH   = (PC_W + IDX_W - 1) / IDX_W;
  localparam int unsigned EXT_W = NCH * IDX_W;
  localparam logic [CNT_W-1:0] CMAX = '1;

  typedef logic [IDX_W-1:0] idx_t;

  function automatic idx_t rotl(input idx_t x, input int unsigned r);
    logic [2*IDX_W-1:0] d;
    d = {x, x} << r;
    return d[2*IDX_W-1:IDX_W];
  endfunction

  // sel=0: plain fold, sel=1: fold with per-slice rotation
  function automatic idx_t hash(input logic [PC_W-1:0] pc, input logic sel);
    logic [EXT_W-1:0] ext;
    idx_t h;
    ext = EXT_W'(pc);
    h   = '0;
    for (int k = 0; k < NCH; k++) begin
      if (sel) h = h ^ rotl(ext[k*IDX_W +: IDX_W], k % IDX_W);
      else     h = h ^ ext[k*IDX_W +: IDX_W];
    end
    return h;
  endfunction

  logic [CNT_W-1:0] cnt_w [N];
  idx_t ins_h1, ins_h2, rem_h1, rem_h2, lkp_h1, lkp_h2;
  logic rem_member;

  assign ins_h1 = hash(ins_pc_i, 1'b0);
  assign ins_h2 = hash(ins_pc_i, 1'b1);
  assign rem_h1 = hash(rem_pc_i, 1'b0);
  assign rem_h2 = hash(rem_pc_i, 1'b1);
  assign lkp_h1 = hash(lkp_pc_i, 1'b0);
  assign lkp_h2 = hash(lkp_pc_i, 1'b1);

  assign rem_member = (cnt_w[rem_h1] != '0) && (cnt_w[rem_h2] != '0);
  assign lkp_hit_o  = (cnt_w[lkp_h1] != '0) && (cnt_w[lkp_h2] != '0);

  for (genvar g = 0; g < N; g++) begin : g_cnt
    logic [CNT_W-1:0] c_q;
    logic inc, dec;
    assign inc = ins_i && (ins_h1 == idx_t'(g) || ins_h2 == idx_t'(g));
    assign dec = rem_i && rem_member && (rem_h1 == idx_t'(g) || rem_h2 == idx_t'(g));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)              c_q <= '0;
      else if (clr_i)           c_q <= '0;
      else if (c_q != CMAX)     c_q <= c_q + CNT_W'(inc) - CNT_W'(dec);
    end
    assign cnt_w[g] = c_q;
  end
endmodule

// File: rtl/vr_reg_scoreboard.sv
module vr_reg_scoreboard #(
  parameter int unsigned NREG   = 32,
  parameter int unsigned RIDX_W = $clog2(NREG)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              flush_i,
  input  logic              vld_i,
  input  logic              pred_i,
  input  logic              alu_i,
  input  logic              wr_i,
  input  logic [RIDX_W-1:0] rd_i,
  input  logic              rs1_vld_i,
  input  logic [RIDX_W-1:0] rs1_i,
  input  logic              rs2_vld_i,
  input  logic [RIDX_W-1:0] rs2_i,
  output logic              skip_o
);
  logic [NREG-1:0] mark_q;

  // reads the registered marks, so a same-slot write is not yet visible
  assign skip_o = vld_i && pred_i &&
                  (!rs1_vld_i || mark_q[rs1_i]) &&
                  (!rs2_vld_i || mark_q[rs2_i]);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            mark_q <= '0;
    else if (flush_i)       mark_q <= '0;
    else if (vld_i && wr_i) mark_q[rd_i] <= pred_i && alu_i;
  end
endmodule

// File: rtl/vr_reuse_sb.sv
module vr_reuse_sb #(
  parameter int unsigned PC_W        = 30,
  parameter int unsigned LAT_W       = 8,
  parameter int unsigned SLOW_LAT    = 20,
  parameter int unsigned TRAIN_ITERS = 8,
  parameter int unsigned FILT_IDX_W  = 6,
  parameter int unsigned CNT_W       = 4,
  parameter int unsigned NREG        = 32,
  localparam int unsigned RIDX_W     = $clog2(NREG)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              loop_start_i,
  input  logic              iter_end_i,
  input  logic              lat_vld_i,
  input  logic [PC_W-1:0]   lat_pc_i,
  input  logic [LAT_W-1:0]  lat_cycles_i,
  input  logic [PC_W-1:0]   lkp_pc_i,
  output logic              lkp_hit_o,
  input  logic              mispred_vld_i,
  input  logic [PC_W-1:0]   mispred_pc_i,
  input  logic              flush_i,
  input  logic              dec_vld_i,
  input  logic              dec_pred_i,
  input  logic              dec_alu_i,
  input  logic              dec_wr_i,
  input  logic [RIDX_W-1:0] dec_rd_i,
  input  logic              dec_rs1_vld_i,
  input  logic [RIDX_W-1:0] dec_rs1_i,
  input  logic              dec_rs2_vld_i,
  input  logic [RIDX_W-1:0] dec_rs2_i,
  output logic              dec_skip_o
);
  logic training;
  logic slow_ins;
  logic slow_rem;

  vr_train_ctrl #(.TRAIN_ITERS(TRAIN_ITERS)) u_train (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .loop_start_i(loop_start_i),
    .iter_end_i  (iter_end_i),
    .training_o  (training)
  );

  assign slow_ins = !loop_start_i && lat_vld_i && training &&
                    (lat_cycles_i >= LAT_W'(SLOW_LAT));
  assign slow_rem = !loop_start_i && mispred_vld_i;

  vr_slow_filter #(
    .PC_W (PC_W),
    .IDX_W(FILT_IDX_W),
    .CNT_W(CNT_W)
  ) u_filter (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clr_i    (loop_start_i),
    .ins_i    (slow_ins),
    .ins_pc_i (lat_pc_i),
    .rem_i    (slow_rem),
    .rem_pc_i (mispred_pc_i),
    .lkp_pc_i (lkp_pc_i),
    .lkp_hit_o(lkp_hit_o)
  );

  vr_reg_scoreboard #(.NREG(NREG), .RIDX_W(RIDX_W)) u_sb (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .flush_i  (flush_i),
    .vld_i    (dec_vld_i),
    .pred_i   (dec_pred_i),
    .alu_i    (dec_alu_i),
    .wr_i     (dec_wr_i),
    .rd_i     (dec_rd_i),
    .rs1_vld_i(dec_rs1_vld_i),
    .rs1_i    (dec_rs1_i),
    .rs2_vld_i(dec_rs2_vld_i),
    .rs2_i    (dec_rs2_i),
    .skip_o   (dec_skip_o)
  );
endmodule

// File: rtl/vr_reuse_sb_chk.sv
module vr_reuse_sb_chk #(
  parameter int unsigned PC_W = 30,
  parameter int unsigned NREG = 32,
  localparam int unsigned RIDX_W = $clog2(NREG)
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              loop_start_i,
  input logic              lat_vld_i,
  input logic [PC_W-1:0]   lkp_pc_i,
  input logic              lkp_hit_o,
  input logic              mispred_vld_i,
  input logic              flush_i,
  input logic              dec_vld_i,
  input logic              dec_pred_i,
  input logic              dec_alu_i,
  input logic              dec_wr_i,
  input logic [RIDX_W-1:0] dec_rd_i,
  input logic              dec_rs1_vld_i,
  input logic [RIDX_W-1:0] dec_rs1_i,
  input logic              dec_rs2_vld_i,
  input logic              dec_skip_o
);
  // R2
  filter_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    loop_start_i |=> !lkp_hit_o);

  // R5
  hit_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!loop_start_i && !lat_vld_i && !mispred_vld_i) |=>
      ((lkp_pc_i == $past(lkp_pc_i)) -> $stable(lkp_hit_o)));

  // R9
  skip_needs_pred_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dec_skip_o |-> (dec_vld_i && dec_pred_i));

  // R7
  mark_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dec_vld_i && dec_wr_i && dec_pred_i && dec_alu_i && !flush_i) |=>
      ((dec_vld_i && dec_pred_i && dec_rs1_vld_i && !dec_rs2_vld_i &&
        dec_rs1_i == $past(dec_rd_i)) -> dec_skip_o));

  // R8
  mark_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dec_vld_i && dec_wr_i && !dec_pred_i && !flush_i) |=>
      !(dec_vld_i && dec_rs1_vld_i && dec_rs1_i == $past(dec_rd_i) && dec_skip_o));

  // R11
  flush_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> !(dec_skip_o && (dec_rs1_vld_i || dec_rs2_vld_i)));
endmodule

bind vr_reuse_sb vr_reuse_sb_chk #(.PC_W(PC_W), .NREG(NREG)) chk_i (.*);

// File: tb/vr_reuse_sb_tb_top.sv
`timescale 1ns/1ps
module vr_reuse_sb_tb_top;
  localparam int PC_W = 30;
  localparam int IDX_W = 6;
  localparam int NENT = 64;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic loop_start_i, iter_end_i, lat_vld_i, mispred_vld_i, flush_i;
  logic [PC_W-1:0] lat_pc_i, lkp_pc_i, mispred_pc_i;
  logic [7:0] lat_cycles_i;
  logic lkp_hit_o, dec_skip_o;
  logic dec_vld_i, dec_pred_i, dec_alu_i, dec_wr_i, dec_rs1_vld_i, dec_rs2_vld_i;
  logic [4:0] dec_rd_i, dec_rs1_i, dec_rs2_i;

  always #2 clk_i = ~clk_i;

  vr_reuse_sb dut_i (.*);

  int vectors = 0;
  int miscompares = 0;
  string cur_req = "R1";

  int m_cnt [NENT];
  bit m_mark [32];
  bit m_trn = 0;
  int m_it = 0;

  logic [PC_W-1:0] pool [8];

  function automatic int h_of(input logic [PC_W-1:0] pc, input bit rot);
    int h = 0;
    for (int k = 0; k < 5; k++) begin
      int s = int'(pc[k*IDX_W +: IDX_W]);
      if (rot) begin
        int r = k % IDX_W;
        s = ((s << r) | (s >> (IDX_W - r))) & (NENT - 1);
      end
      h = h ^ s;
    end
    return h;
  endfunction

  function automatic bit member(input logic [PC_W-1:0] pc);
    return m_cnt[h_of(pc, 0)] != 0 && m_cnt[h_of(pc, 1)] != 0;
  endfunction

  task automatic idle();
    loop_start_i = 0; iter_end_i = 0; lat_vld_i = 0; mispred_vld_i = 0; flush_i = 0;
    lat_pc_i = '0; lkp_pc_i = '0; mispred_pc_i = '0; lat_cycles_i = '0;
    dec_vld_i = 0; dec_pred_i = 0; dec_alu_i = 0; dec_wr_i = 0;
    dec_rs1_vld_i = 0; dec_rs2_vld_i = 0; dec_rd_i = '0; dec_rs1_i = '0; dec_rs2_i = '0;
  endtask

  // compare, advance model, wait for next drive point
  task automatic cyc();
    bit e_hit, e_skip, rem, ins;
    int i1, i2, r1, r2;
    #1;
    e_hit = member(lkp_pc_i);
    e_skip = dec_vld_i && dec_pred_i && (!dec_rs1_vld_i || m_mark[dec_rs1_i]) &&
             (!dec_rs2_vld_i || m_mark[dec_rs2_i]);
    vectors += 2;
    if (lkp_hit_o !== e_hit) begin
      miscompares++;
      $display("FAIL %s lookup pc=%h: got %b exp %b", cur_req, lkp_pc_i, lkp_hit_o, e_hit);
    end
    if (dec_skip_o !== e_skip) begin
      miscompares++;
      $display("FAIL %s skip: got %b exp %b", cur_req, dec_skip_o, e_skip);
    end
    if (rst_ni) begin
      if (loop_start_i) begin
        for (int k = 0; k < NENT; k++) m_cnt[k] = 0;
        m_trn = 1; m_it = 0;
      end else begin
        ins = lat_vld_i && m_trn && lat_cycles_i >= 20;
        rem = mispred_vld_i && member(mispred_pc_i);
        i1 = h_of(lat_pc_i, 0); i2 = h_of(lat_pc_i, 1);
        r1 = h_of(mispred_pc_i, 0); r2 = h_of(mispred_pc_i, 1);
        for (int k = 0; k < NENT; k++) begin
          int inc = (ins && (k == i1 || k == i2)) ? 1 : 0;
          int dec = (rem && (k == r1 || k == r2)) ? 1 : 0;
          if (m_cnt[k] != 15) m_cnt[k] = m_cnt[k] + inc - dec;
        end
        if (iter_end_i && m_trn) begin
          m_it++;
          if (m_it == 8) begin m_trn = 0; m_it = 0; end
        end
      end
      if (flush_i) for (int k = 0; k < 32; k++) m_mark[k] = 0;
      else if (dec_vld_i && dec_wr_i) m_mark[dec_rd_i] = dec_pred_i && dec_alu_i;
    end
    @(negedge clk_i);
  endtask

  task automatic report(input logic [PC_W-1:0] pc, input int lat);
    idle(); lat_vld_i = 1; lat_pc_i = pc; lat_cycles_i = 8'(lat); lkp_pc_i = pc; cyc();
  endtask

  task automatic look(input logic [PC_W-1:0] pc);
    idle(); lkp_pc_i = pc; cyc();
  endtask

  task automatic dec(input bit p, input bit a, input bit w, input int rd,
                     input bit v1, input int s1, input bit v2, input int s2);
    idle(); dec_vld_i = 1; dec_pred_i = p; dec_alu_i = a; dec_wr_i = w; dec_rd_i = 5'(rd);
    dec_rs1_vld_i = v1; dec_rs1_i = 5'(s1); dec_rs2_vld_i = v2; dec_rs2_i = 5'(s2);
  endtask

  initial begin
    #(4 * 200000);
    miscompares++;
    $display("FAIL watchdog expired");
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    for (int k = 0; k < NENT; k++) m_cnt[k] = 0;
    for (int k = 0; k < 32; k++) m_mark[k] = 0;
    for (int k = 0; k < 8; k++) pool[k] = PC_W'(32'h0040_0000 + k * 37 + (k % 3) * 32'h1000);
    idle();
    @(negedge clk_i);
    cur_req = "R1";
    lkp_pc_i = pool[0]; dec(1, 1, 0, 0, 0, 0, 0, 0); cyc();
    rst_ni = 1;
    look(pool[1]);
    dec(1, 0, 0, 0, 1, 4, 1, 9); cyc();

    cur_req = "R3"; // no window yet
    report(pool[0], 40); look(pool[0]);

    cur_req = "R2";
    idle(); loop_start_i = 1; lat_vld_i = 1; lat_pc_i = pool[1]; lat_cycles_i = 50; cyc();
    look(pool[1]);

    cur_req = "R4";
    report(pool[2], 19); look(pool[2]);
    report(pool[3], 20); look(pool[3]);

    cur_req = "R5";
    for (int k = 0; k < 17; k++) report(pool[4], 25);
    look(pool[4]);

    cur_req = "R6";
    idle(); mispred_vld_i = 1; mispred_pc_i = pool[3]; lkp_pc_i = pool[3]; cyc();
    look(pool[3]);
    idle(); mispred_vld_i = 1; mispred_pc_i = pool[5]; cyc();
    report(pool[6], 30);
    idle(); lat_vld_i = 1; lat_pc_i = pool[6]; lat_cycles_i = 30;
    mispred_vld_i = 1; mispred_pc_i = pool[6]; lkp_pc_i = pool[6]; cyc();
    look(pool[6]);
    idle(); mispred_vld_i = 1; mispred_pc_i = pool[4]; lkp_pc_i = pool[4]; cyc();
    look(pool[4]);

    cur_req = "R3";
    for (int k = 0; k < 7; k++) begin idle(); iter_end_i = 1; cyc(); end
    idle(); iter_end_i = 1; lat_vld_i = 1; lat_pc_i = pool[7]; lat_cycles_i = 21; cyc();
    look(pool[7]);
    report(pool[0], 60); look(pool[0]);
    idle(); loop_start_i = 1; cyc();
    look(pool[7]);

    cur_req = "R7";
    dec(1, 1, 1, 3, 0, 0, 0, 0); cyc();
    dec(1, 1, 1, 4, 1, 3, 0, 0); cyc();
    dec(1, 1, 1, 5, 1, 3, 1, 4); cyc();
    cur_req = "R8";
    dec(1, 0, 1, 4, 0, 0, 0, 0); cyc();
    dec(1, 1, 0, 0, 1, 4, 1, 3); cyc();
    dec(0, 1, 1, 3, 0, 0, 0, 0); cyc();
    dec(1, 1, 0, 9, 1, 3, 0, 0); cyc();
    dec(1, 1, 0, 5, 1, 5, 0, 0); cyc();
    cur_req = "R9";
    dec(1, 1, 1, 6, 1, 5, 1, 7); cyc();
    dec(0, 1, 1, 8, 1, 5, 0, 0); cyc();
    cur_req = "R10";
    dec(1, 1, 1, 7, 1, 7, 0, 0); cyc();
    dec(1, 0, 1, 5, 1, 5, 0, 0); cyc();
    dec(1, 1, 0, 0, 1, 5, 0, 0); cyc();
    cur_req = "R11";
    dec(1, 1, 1, 10, 1, 6, 0, 0); flush_i = 1; cyc();
    dec(1, 1, 0, 0, 1, 10, 0, 0); cyc();
    dec(1, 1, 0, 0, 1, 6, 0, 0); cyc();

    cur_req = "R6";
    for (int n = 0; n < 4000; n++) begin
      idle();
      loop_start_i  = ($urandom % 300) == 0;
      iter_end_i    = ($urandom % 12) == 0;
      lat_vld_i     = $urandom % 2;
      lat_pc_i      = pool[$urandom % 8];
      lat_cycles_i  = 8'($urandom % 40);
      mispred_vld_i = ($urandom % 6) == 0;
      mispred_pc_i  = pool[$urandom % 8];
      lkp_pc_i      = pool[$urandom % 8];
      flush_i       = ($urandom % 40) == 0;
      dec_vld_i     = $urandom % 2;
      dec_pred_i    = $urandom % 2;
      dec_alu_i     = ($urandom % 4) != 0;
      dec_wr_i      = ($urandom % 4) != 0;
      dec_rd_i      = 5'($urandom % 8);
      dec_rs1_vld_i = $urandom % 2;
      dec_rs1_i     = 5'($urandom % 8);
      dec_rs2_vld_i = $urandom % 2;
      dec_rs2_i     = 5'($urandom % 8);
      cyc();
    end

    $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule